// File: doc/BRIEF.md
# Programmable LCD Sync Timing Generator

This block produces the horizontal sync, vertical sync and data-enable pins for a dot-clock RGB panel. It also gives the current pixel column, the current line and a one-cycle start-of-frame strobe that a frame fetcher uses to swap buffers. Software does not describe blanking as front and back porches. It gives a total line length in dot clocks, a total frame length in lines, and two wait counts that are measured from the leading edge of each sync pulse to the first active pixel or line. The wait counts already include the pulse width.

A small control state machine has three states: `ST_IDLE`, `ST_ACTIVE` and `ST_FINISH`. `ST_IDLE` moves to `ST_ACTIVE` when `run_i` is sampled high. `ST_ACTIVE` moves to `ST_FINISH` when `stop_i` is sampled high and `run_i` is low. `ST_FINISH` moves back to `ST_ACTIVE` when `run_i` is sampled high. Otherwise `ST_FINISH` moves to `ST_IDLE` on the last dot clock of the current frame. From reset, and in `ST_IDLE`, both counters are held at zero. Two cascaded step counters, one for the line and one for the frame, make the raster. A separate saturating counter measures the vertical pulse in dot clocks when that unit is selected.

The horizontal pulse width sits in the same 32-bit line word as the line period. Two register layouts exist, and the parameter `HS_LAYOUT` selects between them.

Top module: `lcd_sync_gen`

## Requirements
- R1: While running, `x_o` counts 0 up to P-1 and then wraps to 0. P is `line_word_i[17:0]`. `y_o` increments at each wrap and returns to 0 after `frame_lines_i` lines.
- R2: The horizontal pulse is active while `x_o` is less than W. With `HS_LAYOUT`=0, W is `line_word_i[31:24]` and bits [23:18] are ignored. With `HS_LAYOUT`=1, W is `line_word_i[31:18]`.
- R3: Data-enable is active exactly when `hwait_i` <= `x_o` < `hwait_i`+`hvalid_i` and `vwait_i` <= `y_o` < `vwait_i`+`vactive_i`.
- R4: With `vs_unit_clk_i`=0, the vertical pulse is active while `y_o` < `vs_width_i`. With `vs_unit_clk_i`=1, it is active for the first `vs_width_i` dot clocks of each frame.
- R5: Each sync pin equals its polarity bit (`hs_high_i`, `vs_high_i`, `de_high_i`) while its signal is active, and equals the complement of that bit while inactive.
- R6: While `sync_on_i` is 0, all three pins sit at their inactive level. `x_o`, `y_o` and `sof_o` are not affected.
- R7: `sof_o` is high for one cycle in the first dot clock of every frame (x=0, y=0 while running), which is the leading edge of the vertical pulse.
- R8: In `ST_IDLE`, `x_o`=`y_o`=0, `sof_o`=0 and the pins are inactive. `stop_i` has no effect there. The first running cycle (x=0, y=0) is the cycle after `run_i` is sampled.
- R9: A stop sampled in `ST_ACTIVE` lets the current frame finish. The block then returns to `ST_IDLE`.
- R10: A run sampled in `ST_FINISH` cancels the stop, and frames continue without a break.
- R11: After reset the block is in `ST_IDLE`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Dot clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| run_i | input | 1 | Start (or resume) raster generation |
| stop_i | input | 1 | Stop at the end of the current frame |
| sync_on_i | input | 1 | Enable for the sync pins |
| line_word_i | input | 32 | Line period [17:0] plus horizontal pulse width (layout per `HS_LAYOUT`) |
| hwait_i | input | 12 | Dot clocks from line start to the first active pixel |
| hvalid_i | input | 18 | Active pixels per line |
| frame_lines_i | input | 16 | Frame period in lines |
| vs_width_i | input | 18 | Vertical pulse width, in lines or dot clocks |
| vs_unit_clk_i | input | 1 | 1: vertical pulse width counted in dot clocks |
| vwait_i | input | 16 | Lines from frame start to the first active line |
| vactive_i | input | 16 | Active lines per frame |
| hs_high_i | input | 1 | Horizontal pulse active high |
| vs_high_i | input | 1 | Vertical pulse active high |
| de_high_i | input | 1 | Data-enable active high |
| hsync_o | output | 1 | Horizontal sync pin |
| vsync_o | output | 1 | Vertical sync pin |
| de_o | output | 1 | Data-enable pin |
| x_o | output | 18 | Current dot position in the line |
| y_o | output | 16 | Current line in the frame |
| sof_o | output | 1 | Start-of-frame strobe |

## Verification
The bench builds two copies side by side. One uses `HS_LAYOUT`=0 and the other uses `HS_LAYOUT`=1, and both take the same timing. This puts both pulse-width field positions under the same stimulus. Random junk in bits [23:18] tests that the narrow layout ignores them. A directed 300-clock pulse shows that the narrow layout truncates the width to 8 bits. The default counter widths are kept. Random line lengths of 8 to 20 clocks and frames of 3 to 8 lines make every window edge, every wrap and every stop or cancel point reachable within a few hundred cycles per configuration.

// File: rtl/lcd_sync_pkg.sv
package lcd_sync_pkg;

    typedef enum logic [1:0] {
        ST_IDLE   = 2'd0,
        ST_ACTIVE = 2'd1,
        ST_FINISH = 2'd2
    } sync_state_e;

    // Pin level: the polarity bit while enabled and active, its complement otherwise.
    function automatic logic pin_level(input logic act, input logic en, input logic high);
        return (act && en) ? high : ~high;
    endfunction

endpackage

// File: rtl/lcd_sync_ctrl.sv
module lcd_sync_ctrl
    import lcd_sync_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic run_i,
    input  logic stop_i,
    input  logic frame_end_i,
    output logic running_o
);

    sync_state_e state_q, state_d;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:   if (run_i) state_d = ST_ACTIVE;
            ST_ACTIVE: if (stop_i && !run_i) state_d = ST_FINISH;
            ST_FINISH: begin
                if (run_i)            state_d = ST_ACTIVE;
                else if (frame_end_i) state_d = ST_IDLE;
            end
            default:   state_d = ST_IDLE;
        endcase
    end

    always_comb running_o = (state_q != ST_IDLE);

    // R8: stop (or nothing) in idle keeps the block idle
    p_idle_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_IDLE && !run_i) |=> (state_q == ST_IDLE));

    // R9: a finishing raster ends at the frame boundary
    p_finish_exit_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_FINISH && frame_end_i && !run_i) |=> !running_o);

    // R10: a run in the finishing state keeps the raster going
    p_cancel_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_FINISH && run_i) |=> (state_q == ST_ACTIVE));

endmodule

// File: rtl/lcd_step_counter.sv
module lcd_step_counter #(
    parameter int W = 18
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         clr_i,
    input  logic         step_i,
    input  logic [W-1:0] limit_i,
    output logic [W-1:0] count_o,
    output logic         last_o
);

    localparam int WX = W + 1;

    logic [WX-1:0] next_ext;

    always_comb begin
        next_ext = {1'b0, count_o} + WX'(1);
        last_o   = (next_ext >= {1'b0, limit_i});
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)      count_o <= '0;
        else if (clr_i)  count_o <= '0;
        else if (step_i) count_o <= last_o ? '0 : next_ext[W-1:0];
    end

    // R1: the counter wraps after its limit
    p_wrap_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (step_i && last_o && !clr_i) |=> (count_o == '0));

    // R1: the counter advances by one below its limit
    p_step_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (step_i && !last_o && !clr_i) |=> (count_o == $past(count_o) + W'(1)));

    // R1: without a step the count holds
    p_hold_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (!step_i && !clr_i) |=> $stable(count_o));

endmodule

// File: rtl/lcd_sync_gen.sv
module lcd_sync_gen
    import lcd_sync_pkg::*;
#(
    parameter int HS_LAYOUT = 0,
    parameter int HW        = 18,
    parameter int VW        = 16,
    parameter int HWAIT_W   = 12,
    parameter int VSW_W     = 18
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              run_i,
    input  logic              stop_i,
    input  logic              sync_on_i,
    input  logic [31:0]       line_word_i,
    input  logic [HWAIT_W-1:0] hwait_i,
    input  logic [HW-1:0]     hvalid_i,
    input  logic [VW-1:0]     frame_lines_i,
    input  logic [VSW_W-1:0]  vs_width_i,
    input  logic              vs_unit_clk_i,
    input  logic [VW-1:0]     vwait_i,
    input  logic [VW-1:0]     vactive_i,
    input  logic              hs_high_i,
    input  logic              vs_high_i,
    input  logic              de_high_i,
    output logic              hsync_o,
    output logic              vsync_o,
    output logic              de_o,
    output logic [HW-1:0]     x_o,
    output logic [VW-1:0]     y_o,
    output logic              sof_o
);

    localparam int HSW_BITS = (HS_LAYOUT == 0) ? 8 : 14;
    localparam int HSW_LSB  = 32 - HSW_BITS;
    localparam int HX       = HW + 1;
    localparam int VX       = VW + 1;
    localparam int CMPW     = (VSW_W > VW) ? VSW_W : VW;

    logic            running;
    logic            h_last, v_last, frame_end;
    logic [HW-1:0]   period, hs_width;
    logic [VSW_W-1:0] fclk_q;
    logic            hs_act, vs_act, de_act, h_win, v_win;
    logic            unused_cfg_bits;

    assign period          = line_word_i[HW-1:0];
    assign unused_cfg_bits = ^line_word_i;

    generate
        if (HS_LAYOUT == 0) begin : g_narrow
            assign hs_width = HW'(line_word_i[HSW_LSB +: HSW_BITS]);
        end else begin : g_wide
            assign hs_width = HW'(line_word_i[HSW_LSB +: HSW_BITS]);
        end
    endgenerate

    lcd_sync_ctrl u_ctrl (
        .clk         (clk),
        .rst_n       (rst_n),
        .run_i       (run_i),
        .stop_i      (stop_i),
        .frame_end_i (frame_end),
        .running_o   (running)
    );

    lcd_step_counter #(.W(HW)) u_hcnt (
        .clk     (clk),
        .rst_n   (rst_n),
        .clr_i   (!running),
        .step_i  (running),
        .limit_i (period),
        .count_o (x_o),
        .last_o  (h_last)
    );

    lcd_step_counter #(.W(VW)) u_vcnt (
        .clk     (clk),
        .rst_n   (rst_n),
        .clr_i   (!running),
        .step_i  (running && h_last),
        .limit_i (frame_lines_i),
        .count_o (y_o),
        .last_o  (v_last)
    );

    assign frame_end = running && h_last && v_last;

    // dot clocks since frame start, saturating
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                      fclk_q <= '0;
        else if (!running || frame_end)  fclk_q <= '0;
        else if (fclk_q != '1)           fclk_q <= fclk_q + VSW_W'(1);
    end

    always_comb begin
        h_win  = ({1'b0, x_o} >= HX'(hwait_i)) &&
                 ({1'b0, x_o} <  (HX'(hwait_i) + HX'(hvalid_i)));
        v_win  = ({1'b0, y_o} >= VX'(vwait_i)) &&
                 ({1'b0, y_o} <  (VX'(vwait_i) + VX'(vactive_i)));
        hs_act = running && (x_o < hs_width);
        de_act = running && h_win && v_win;
        if (vs_unit_clk_i) vs_act = running && (fclk_q < vs_width_i);
        else               vs_act = running && (CMPW'(y_o) < CMPW'(vs_width_i));
    end

    always_comb begin
        hsync_o = pin_level(hs_act, sync_on_i, hs_high_i);
        vsync_o = pin_level(vs_act, sync_on_i, vs_high_i);
        de_o    = pin_level(de_act, sync_on_i, de_high_i);
        sof_o   = running && (x_o == '0) && (y_o == '0);
    end

    // R6: disabled sync pins sit at their inactive level
    p_inactive_r6: assert property (@(posedge clk) disable iff (!rst_n)
        !sync_on_i |-> (hsync_o == ~hs_high_i && vsync_o == ~vs_high_i && de_o == ~de_high_i));

    // R8: the idle state parks both counters at zero
    p_idle_zero_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !running |-> (x_o == '0 && y_o == '0 && !sof_o));

    // R7: the frame strobe lasts one cycle when a line is longer than one clock
    p_sof_pulse_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (sof_o && period > HW'(1)) |=> !sof_o);

    // R4: in clock units the vertical pulse starts with the frame
    p_vs_start_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (sof_o && vs_unit_clk_i && vs_width_i != '0 && sync_on_i) |-> (vsync_o == vs_high_i));

endmodule

// File: tb/lcd_sync_gen_bench.sv
module lcd_sync_gen_bench;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic run_i = 1'b0, stop_i = 1'b0, sync_on_i = 1'b0;
    logic [31:0] word_n, word_w;
    logic [11:0] hwait_i;
    logic [17:0] hvalid_i, vs_width_i;
    logic [15:0] frame_lines_i, vwait_i, vactive_i;
    logic vs_unit_clk_i, hs_high_i, vs_high_i, de_high_i;
    logic hs_n, vs_n, de_n, sof_n, hs_w, vs_w, de_w, sof_w;
    logic [17:0] x_n, x_w;
    logic [15:0] y_n, y_w;

    int n_tests = 0, n_fail = 0;
    int cP, cF, cHsw, cHw, cHv, cVsw, cVw, cVa, cJunk;
    bit cVunit, cHsH, cVsH, cDeH, cOn;

    always #5 clk = ~clk;

    always_comb begin
        word_n        = {cHsw[7:0], cJunk[5:0], cP[17:0]};
        word_w        = {cHsw[13:0], cP[17:0]};
        hwait_i       = cHw[11:0];
        hvalid_i      = cHv[17:0];
        frame_lines_i = cF[15:0];
        vs_width_i    = cVsw[17:0];
        vs_unit_clk_i = cVunit;
        vwait_i       = cVw[15:0];
        vactive_i     = cVa[15:0];
        hs_high_i     = cHsH;
        vs_high_i     = cVsH;
        de_high_i     = cDeH;
        sync_on_i     = cOn;
    end

    lcd_sync_gen #(.HS_LAYOUT(0)) u_lcd_sync_gen (
        .clk(clk), .rst_n(rst_n), .run_i(run_i), .stop_i(stop_i), .sync_on_i(sync_on_i),
        .line_word_i(word_n), .hwait_i(hwait_i), .hvalid_i(hvalid_i),
        .frame_lines_i(frame_lines_i), .vs_width_i(vs_width_i), .vs_unit_clk_i(vs_unit_clk_i),
        .vwait_i(vwait_i), .vactive_i(vactive_i), .hs_high_i(hs_high_i), .vs_high_i(vs_high_i),
        .de_high_i(de_high_i), .hsync_o(hs_n), .vsync_o(vs_n), .de_o(de_n),
        .x_o(x_n), .y_o(y_n), .sof_o(sof_n));

    lcd_sync_gen #(.HS_LAYOUT(1)) u_lcd_sync_gen_wide (
        .clk(clk), .rst_n(rst_n), .run_i(run_i), .stop_i(stop_i), .sync_on_i(sync_on_i),
        .line_word_i(word_w), .hwait_i(hwait_i), .hvalid_i(hvalid_i),
        .frame_lines_i(frame_lines_i), .vs_width_i(vs_width_i), .vs_unit_clk_i(vs_unit_clk_i),
        .vwait_i(vwait_i), .vactive_i(vactive_i), .hs_high_i(hs_high_i), .vs_high_i(vs_high_i),
        .de_high_i(de_high_i), .hsync_o(hs_w), .vsync_o(vs_w), .de_o(de_w),
        .x_o(x_w), .y_o(y_w), .sof_o(sof_w));

    task automatic chk(input string tag, input int act, input int exp);
        n_tests++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    function automatic bit exp_pin(input bit act, input bit high);
        return (cOn && act) ? high : !high;
    endfunction

    // Expected outputs at cycle t of a raster (t = 0 is the first running cycle).
    task automatic check_cycle(input int t, input bit run, input string stag);
        int fp, fc, h, v;
        bit ehs_n, ehs_w, evs, ede, esof;
        h = 0; v = 0; fc = 0;
        ehs_n = 0; ehs_w = 0; evs = 0; ede = 0; esof = 0;
        if (run) begin
            fp    = cP * cF;
            fc    = t % fp;
            h     = fc % cP;
            v     = fc / cP;
            ehs_w = h < cHsw;
            ehs_n = h < (cHsw & 255);
            ede   = (h >= cHw) && (h < cHw + cHv) && (v >= cVw) && (v < cVw + cVa);
            evs   = cVunit ? (fc < cVsw) : (v < cVsw);
            esof  = (fc == 0);
        end
        chk({stag, " R1 x narrow"}, int'(x_n), h);
        chk({stag, " R1 y narrow"}, int'(y_n), v);
        chk({stag, " R1 x wide"}, int'(x_w), h);
        chk({stag, " R1 y wide"}, int'(y_w), v);
        chk({stag, " R2 R5 R6 hsync narrow"}, int'(hs_n), int'(exp_pin(ehs_n, cHsH)));
        chk({stag, " R2 R5 R6 hsync wide"}, int'(hs_w), int'(exp_pin(ehs_w, cHsH)));
        chk({stag, " R4 R5 R6 vsync"}, int'(vs_n), int'(exp_pin(evs, cVsH)));
        chk({stag, " R4 vsync wide"}, int'(vs_w), int'(exp_pin(evs, cVsH)));
        chk({stag, " R3 R5 R6 de"}, int'(de_n), int'(exp_pin(ede, cDeH)));
        chk({stag, " R3 de wide"}, int'(de_w), int'(exp_pin(ede, cDeH)));
        chk({stag, " R7 sof"}, int'(sof_n), int'(esof));
        chk({stag, " R7 sof wide"}, int'(sof_w), int'(esof));
    endtask

    // One raster: start, stop in the second frame (optionally cancel once), drain to idle.
    task automatic run_cfg(input bit cancel);
        int fp, ts, end_t;
        fp    = cP * cF;
        ts    = fp + int'($urandom_range(0, fp - 3));
        end_t = cancel ? 3 * fp : 2 * fp;
        @(negedge clk) run_i = 1'b1;
        @(negedge clk) run_i = 1'b0;
        for (int t = 0; t < end_t + 3; t++) begin
            check_cycle(t, t < end_t, (t < end_t) ? "run" : "R9 R10 after stop");
            stop_i = (t == ts) || (cancel && t == 2 * fp);
            run_i  = cancel && (t == ts + 1);
            @(negedge clk);
        end
        stop_i = 1'b0;
        run_i  = 1'b0;
    endtask

    task automatic rand_cfg();
        cP     = int'($urandom_range(8, 20));
        cF     = int'($urandom_range(3, 8));
        cHsw   = int'($urandom_range(0, cP - 1));
        cHw    = int'($urandom_range(0, cP - 1));
        cHv    = int'($urandom_range(0, cP));
        cVunit = 1'($urandom_range(0, 1));
        cVsw   = cVunit ? int'($urandom_range(0, 2 * cP)) : int'($urandom_range(0, cF));
        cVw    = int'($urandom_range(0, cF - 1));
        cVa    = int'($urandom_range(0, cF));
        cHsH   = 1'($urandom_range(0, 1));
        cVsH   = 1'($urandom_range(0, 1));
        cDeH   = 1'($urandom_range(0, 1));
        cOn    = ($urandom_range(0, 3) != 0);
        cJunk  = int'($urandom_range(0, 63));
    endtask

    initial begin
        void'($urandom(32'd2024));
        cP = 10; cF = 4; cHsw = 2; cHw = 3; cHv = 5; cVsw = 1; cVw = 1; cVa = 2;
        cVunit = 0; cHsH = 0; cVsH = 0; cDeH = 1; cOn = 1; cJunk = 63;
        repeat (3) @(negedge clk);
        // R11: reset state is idle
        check_cycle(0, 0, "R11 reset");
        rst_n = 1'b1;
        @(negedge clk);
        check_cycle(0, 0, "R11 R8 idle after reset");
        // R8: stop in idle has no effect
        stop_i = 1'b1;
        @(negedge clk) stop_i = 1'b0;
        for (int k = 0; k < 3; k++) begin
            check_cycle(0, 0, "R8 stop in idle");
            @(negedge clk);
        end
        // directed: first start, plain stop
        run_cfg(0);
        // directed: cancel of a pending stop (R10)
        run_cfg(1);
        // directed: wide pulse, narrow layout keeps the low 8 bits (R2)
        cP = 320; cF = 3; cHsw = 300; cHw = 310; cHv = 20; cVunit = 1; cVsw = 700;
        cVw = 0; cVa = 3; cHsH = 1; cVsH = 1; cOn = 1;
        run_cfg(0);
        // directed: enable window past the line end, zero widths, pins disabled (R3, R6)
        cP = 9; cF = 3; cHsw = 0; cHw = 7; cHv = 9; cVunit = 0; cVsw = 0;
        cVw = 2; cVa = 5; cOn = 0;
        run_cfg(0);
        for (int n = 0; n < 24; n++) begin
            rand_cfg();
            run_cfg(n % 4 == 1);
        end
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        n_tests++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

endmodule